// File: doc/BRIEF.md
# Binary Region Contour Tracer

The tracer holds a one-bit-per-pixel region mask for a frame of 384 by 240 pixels. After a start command it scans the mask in raster order. When it finds a marked pixel that opens a new region, it walks that region's boundary clockwise. It streams the column and row of every boundary pixel it steps on. Each contour's points carry a running count, and the final point carries a last flag. When a contour closes, the scan continues from the pixel after the one that opened it. A one-cycle done pulse follows the last raster position. The same block serves a skin-tone mask or a non-skin mask without change.

Each cycle of work produces exactly one result. During the scan a cycle either advances the scan position or opens a trace. During a trace a cycle either hands one boundary point downstream or waits on backpressure. The output rate therefore depends on the image content. The mask is loaded one pixel at a time through a write port while the block is idle.

Top module: `contour_tracer`

## Requirements
- R1: After reset, `out_valid` and `frame_done` are low and the block is idle. It waits for `start`.
- R2: The scan visits pixels in raster order: x rises along a line, then y rises. A trace opens on a pixel only when all of these hold: the pixel is marked, it has not been stepped on by a trace in this frame, and its west neighbour is unmarked or lies outside the frame. Contours therefore come out in the raster order of their opening pixels, and scanning resumes right after the opening pixel.
- R3: Directions are coded 0=E, 1=SE, 2=S, 3=SW, 4=W, 5=NW, 6=N, 7=NE, with y growing downwards.
  - Each step searches the 8 neighbours clockwise, starting one past the backtrack direction. The initial backtrack is W.
  - After a move in direction d, the new backtrack is d+6 for even d and d+5 for odd d, taken modulo 8.
  - A contour closes when a move would re-enter the opening pixel from a direction whose next search there would repeat the first departure.
  - Example: a 2x2 square at (5,4) yields (5,4),(6,4),(6,5),(5,5). A diagonal pair (9,1),(10,2) yields (9,1),(10,2).
- R4: Points of one contour carry `out_count` values 1, 2, 3, ... in order. `out_last` is high only on the final point.
- R5: A marked pixel with no marked neighbour yields a single point with count 1 and last high.
- R6: Pixels outside the frame count as unmarked. In particular, the last pixel of one line is not a neighbour of the first pixel of the next line.
- R7: No region is traced twice within a frame. A new `start` forgets all earlier trace marks, so a rerun over the same mask reproduces the same stream.
- R8: While `out_valid` is high and `out_ready` is low, the point and its flags are held unchanged. Backpressure does not change the stream's content.
- R9: `frame_done` is high for exactly one cycle, after the final raster position has been scanned and after the frame's last point.
- R10: A write with `wr_en` high sets the mask pixel at (`wr_x`, `wr_y`) to `wr_bit` only while the block is idle. Writes and `start` pulses that arrive while a frame is running are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Mask pixel write strobe |
| wr_x | input | 9 | Column of the pixel written |
| wr_y | input | 8 | Row of the pixel written |
| wr_bit | input | 1 | New mask value (1 = region) |
| start | input | 1 | Begin one pass over the frame |
| out_valid | output | 1 | Boundary point available |
| out_ready | input | 1 | Downstream accepts the point |
| out_x | output | 9 | Column of the boundary point |
| out_y | output | 8 | Row of the boundary point |
| out_last | output | 1 | Final point of the current contour |
| out_count | output | 16 | Position of the point within its contour, from 1 |
| frame_done | output | 1 | One-cycle pulse after the whole frame has been scanned |

## Verification
The properties allow `out_ready` to drop in any cycle. They expect the mask to stay fixed during a frame, which the block itself enforces by dropping writes while busy. The stimulus loads shapes only while the block is idle, except for one deliberate write and one deliberate `start` pulse during a running frame. Those two exist to show that busy-time commands are ignored. The shapes are isolated pixels, a diagonal pair, a square and a line, all free of holes. A rim pixel inside a hole has an unmarked west neighbour and would open a contour of its own.

// File: rtl/contour_tracer.sv
module contour_tracer #(
  parameter int W  = 384,
  parameter int H  = 240,
  parameter int XW = 9,
  parameter int YW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [XW-1:0] wr_x,
  input  logic [YW-1:0] wr_y,
  input  logic          wr_bit,
  input  logic          start,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [XW-1:0] out_x,
  output logic [YW-1:0] out_y,
  output logic          out_last,
  output logic [CW-1:0] out_count,
  output logic          frame_done
);
  localparam int XI = $clog2(W);
  localparam int YI = $clog2(H);
  localparam logic [XW-1:0] XLAST = XW'(W - 1);
  localparam logic [YW-1:0] YLAST = YW'(H - 1);

  typedef enum logic [1:0] {IDLE, SCAN, TRACE} state_t;

  function automatic int dxf(input logic [2:0] d);
    case (d)
      3'd0, 3'd1, 3'd7: return 1;
      3'd3, 3'd4, 3'd5: return -1;
      default:          return 0;
    endcase
  endfunction

  function automatic int dyf(input logic [2:0] d);
    case (d)
      3'd1, 3'd2, 3'd3: return 1;
      3'd5, 3'd6, 3'd7: return -1;
      default:          return 0;
    endcase
  endfunction

  logic [W-1:0] mask [H];
  logic [W-1:0] vis  [H];

  state_t        st;
  logic [XW-1:0] px, sx, nxp;
  logic [YW-1:0] py, sy, nyp;
  logic [2:0]    bt, d0, dir, nbt, dd;
  logic [7:0]    nb, sn;
  logic          first, done, fnd, fnd2, close;
  logic [CW-1:0] cnt;

  always_comb begin
    int nx, ny;
    nb = '0;
    for (int k = 0; k < 8; k++) begin
      nx = int'(px) + dxf(3'(k));
      ny = int'(py) + dyf(3'(k));
      if (nx >= 0 && nx < W && ny >= 0 && ny < H)
        nb[k] = mask[YI'(ny)][XI'(nx)];
    end
  end

  always_comb begin
    logic [2:0] j;
    fnd = 1'b0;
    dir = bt;
    for (int i = 1; i < 8; i++) begin
      j = bt + 3'(i);
      if (!fnd && nb[j]) begin
        fnd = 1'b1;
        dir = j;
      end
    end
    nbt = dir + (dir[0] ? 3'd5 : 3'd6);
    nxp = XW'(int'(px) + dxf(dir));
    nyp = YW'(int'(py) + dyf(dir));
    fnd2 = 1'b0;
    dd = nbt;
    for (int i = 1; i < 8; i++) begin
      j = nbt + 3'(i);
      if (!fnd2 && sn[j]) begin
        fnd2 = 1'b1;
        dd = j;
      end
    end
    close = !fnd || (!first && nxp == sx && nyp == sy && fnd2 && dd == d0);
  end

  wire here     = mask[py[YI-1:0]][px[XI-1:0]];
  wire open_ok  = here && !vis[py[YI-1:0]][px[XI-1:0]] && !nb[4];
  wire hs       = out_valid && out_ready;
  wire wr_ok    = st == IDLE && wr_en && int'(wr_x) < W && int'(wr_y) < H;

  assign out_valid  = st == TRACE;
  assign out_x      = px;
  assign out_y      = py;
  assign out_last   = close;
  assign out_count  = cnt;
  assign frame_done = done;

  always_ff @(posedge clk) begin
    if (wr_ok) mask[wr_y[YI-1:0]][wr_x[XI-1:0]] <= wr_bit;
  end

  always_ff @(posedge clk) begin
    if (st == IDLE && start) begin
      for (int r = 0; r < H; r++) vis[r] <= '0;
    end else if (hs) begin
      vis[py[YI-1:0]][px[XI-1:0]] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; done <= 1'b0; first <= 1'b0;
      px <= '0; py <= '0; sx <= '0; sy <= '0;
      bt <= 3'd4; d0 <= '0; sn <= '0; cnt <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          st <= SCAN; px <= '0; py <= '0;
        end
        SCAN: if (open_ok) begin
          st <= TRACE; sx <= px; sy <= py;
          bt <= 3'd4; first <= 1'b1; cnt <= CW'(1);
        end else if (px == XLAST) begin
          px <= '0;
          if (py == YLAST) begin
            st <= IDLE; done <= 1'b1;
          end else begin
            py <= py + 1'b1;
          end
        end else begin
          px <= px + 1'b1;
        end
        TRACE: if (hs) begin
          if (first) begin
            sn <= nb; d0 <= dir;
          end
          first <= 1'b0;
          if (close) begin
            st <= SCAN; px <= sx; py <= sy;
          end else begin
            px <= nxp; py <= nyp; bt <= nbt; cnt <= cnt + 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/contour_tracer_chk.sv
module contour_tracer_chk #(
  parameter int W  = 384,
  parameter int H  = 240,
  parameter int XW = 9,
  parameter int YW = 8,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic [XW-1:0] out_x,
  input logic [YW-1:0] out_y,
  input logic          out_last,
  input logic [CW-1:0] out_count,
  input logic          frame_done
);
  logic fst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fst <= 1'b1;
    else if (out_valid && out_ready) fst <= out_last;
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_x) && $stable(out_y)
      && $stable(out_last) && $stable(out_count));

  // R4
  first_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && fst |-> out_count == CW'(1));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid && out_count == $past(out_count) + 1'b1);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && out_valid));

  // R6
  in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_x) < W && int'(out_y) < H);
endmodule

bind contour_tracer contour_tracer_chk #(.W(W), .H(H), .XW(XW), .YW(YW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_x(out_x), .out_y(out_y), .out_last(out_last), .out_count(out_count),
  .frame_done(frame_done)
);

// File: tb/contour_tracer_bench.sv
`timescale 1ns/1ps
module contour_tracer_bench;
  localparam int W = 16, H = 10, XW = 9, YW = 8, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_bit = 1'b0, start = 1'b0, out_ready = 1'b1;
  logic [XW-1:0] wr_x = '0, out_x;
  logic [YW-1:0] wr_y = '0, out_y;
  logic out_valid, out_last, frame_done;
  logic [CW-1:0] out_count;

  always #2.5 clk = ~clk;

  contour_tracer #(.W(W), .H(H), .XW(XW), .YW(YW), .CW(CW)) u_contour_tracer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_x(wr_x), .wr_y(wr_y),
    .wr_bit(wr_bit), .start(start), .out_valid(out_valid), .out_ready(out_ready),
    .out_x(out_x), .out_y(out_y), .out_last(out_last), .out_count(out_count),
    .frame_done(frame_done)
  );

  // point word: {x[8:0], y[7:0], last, count[15:0]}
  localparam logic [33:0] EXP_A [11] = '{
    {9'd9,  8'd1, 1'b0, 16'd1}, {9'd10, 8'd2, 1'b1, 16'd2},
    {9'd3,  8'd2, 1'b1, 16'd1},
    {9'd5,  8'd4, 1'b0, 16'd1}, {9'd6,  8'd4, 1'b0, 16'd2},
    {9'd6,  8'd5, 1'b0, 16'd3}, {9'd5,  8'd5, 1'b1, 16'd4},
    {9'd2,  8'd7, 1'b0, 16'd1}, {9'd3,  8'd7, 1'b0, 16'd2},
    {9'd4,  8'd7, 1'b0, 16'd3}, {9'd3,  8'd7, 1'b1, 16'd4}
  };
  localparam logic [33:0] EXP_C [4] = '{
    {9'd0,  8'd0, 1'b1, 16'd1}, {9'd15, 8'd3, 1'b1, 16'd1},
    {9'd0,  8'd4, 1'b1, 16'd1}, {9'd15, 8'd9, 1'b1, 16'd1}
  };

  int checks = 0, fails = 0;
  logic [33:0] rec [64];
  int rn = 0, done_cnt = 0;
  logic done_seen = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (rn < 64) rec[rn] = {out_x, out_y, out_last, out_count};
        rn = rn + 1;
      end
      if (frame_done) begin
        done_seen = 1'b1;
        done_cnt = done_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_px(input int x, input int y, input bit v);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_x = XW'(x); wr_y = YW'(y); wr_bit = v;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic load_a(input bit v);
    write_px(9, 1, v);  write_px(10, 2, v); write_px(3, 2, v);
    write_px(5, 4, v);  write_px(6, 4, v);  write_px(5, 5, v); write_px(6, 5, v);
    write_px(2, 7, v);  write_px(3, 7, v);  write_px(4, 7, v);
  endtask

  task automatic run_frame(input bit bp);
    int k = 0;
    rn = 0; done_cnt = 0; done_seen = 1'b0;
    pulse_start();
    while (!done_seen) begin
      @(posedge clk); #1;
      if (bp) out_ready = (k % 3) != 1;
      k++;
    end
    out_ready = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_a(input string req);
    check(rn == 11, req, 64'(rn), 64'd11);
    for (int i = 0; i < 11; i++)
      check(rec[i] == EXP_A[i], req, 64'(rec[i]), 64'(EXP_A[i]));
    check(done_cnt == 1, "R9", 64'(done_cnt), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0);
    check(frame_done == 1'b0, "R1", 64'(frame_done), 64'd0);
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0 && frame_done == 1'b0, "R1", 64'({out_valid, frame_done}), 64'd0);

    // R2 R3 R4 R5: raster order, tracing, counts, isolated pixel
    load_a(1'b1);
    run_frame(1'b0);
    check_a("R3");

    // R8 backpressure, R10 busy write and busy start ignored
    fork
      run_frame(1'b1);
      begin
        repeat (30) @(posedge clk);
        write_px(12, 1, 1'b1);
        pulse_start();
      end
    join
    check_a("R8");

    // R7 rerun reproduces, R10 pixel (12,1) never landed
    run_frame(1'b0);
    check_a("R10");

    // R5 R6 frame corners and no line wrap
    load_a(1'b0);
    write_px(12, 1, 1'b0);
    write_px(0, 0, 1'b1);  write_px(15, 3, 1'b1);
    write_px(0, 4, 1'b1);  write_px(15, 9, 1'b1);
    run_frame(1'b0);
    check(rn == 4, "R6", 64'(rn), 64'd4);
    for (int i = 0; i < 4; i++)
      check(rec[i] == EXP_C[i], "R6", 64'(rec[i]), 64'(EXP_C[i]));
    check(done_cnt == 1, "R9", 64'(done_cnt), 64'd1);
    check(out_valid == 1'b0, "R9", 64'(out_valid), 64'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule